// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind a byte-wide register bus. Software picks a channel and its counting mode through a control port. It then loads each channel's start value as two byte writes on that channel's data port. Counting moves forward only on cycles where the `tick` enable input is high. Channel 0 gives the interrupt request. Channel 2's output can be read on a separate status port.

Each channel runs in one of two ways. In one-shot mode it fires once at terminal count, raises its output state and stops. In any other mode it reloads from its start value and fires once per period. Software can capture a channel's current count into an output latch, either with a per-channel latch command or with a read-back command that covers several channels at once. The read-back command can also queue a status byte. The data port returns the latch as a low byte followed by a high byte. A queued status byte is returned ahead of the latch bytes.

Top module: `pit_timer3`

## Requirements
- R1: After reset, every channel has start value 0xFFFF, count 0xFFFF, mode 0, output state 0 and output latch 0x0000, and both the read and write byte phases point at the low byte.
- R2: Bus addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port and address 4 is the status port. In a control word, bits 7:6 select the channel, and the value 3 in that field marks a read-back command. The channels count independently of one another.
- R3: A control word with bits 5:4 = 00 and a channel select copies that channel's current count into its output latch, and leaves its mode unchanged.
- R4: A control word with a channel select and bits 5:4 not equal to 00 stores bits 3:1 as that channel's mode, whatever the access value is.
- R5: A data-port write stores the low byte first, then the high byte. The high-byte write restarts the channel: its output state clears, the first following tick loads the start value, and each later tick decrements the count. The tick that finds the count at 1 is the terminal tick, which for start value N is the (N+1)th tick after the restart.
- R6: A written start value of 0x0000 is stored as 0xFFFF.
- R7: Reads of a data port return the output latch's low byte and high byte in turn, beginning with the low byte.
- R8: A read-back command (bits 7:6 = 11) with bit 4 = 0 queues a status byte on every channel whose select bit is set: bit 1 selects channel 0, bit 2 channel 1 and bit 3 channel 2. The next read of that channel returns 0x30 OR (mode << 1) and clears the queued byte. That read does not advance the byte phase.
- R9: A read-back command with bit 5 = 0 copies the current count of every selected channel into its output latch.
- R10: In mode 0, the terminal tick fires once, sets the output state to 1, sets the count to 0 and stops the channel until the next restart.
- R11: In every mode other than 0, the terminal tick fires and reloads the count from the start value, so the channel fires again every N ticks.
- R12: `irq` goes high for the one cycle after a terminal tick of channel 0. Channels 1 and 2 never drive it.
- R13: A status-port read returns bit 5 = channel 2 output state when channel 2 is in mode 0, and bit 0 = 1 when channel 2 is in mode 3 and its count is greater than half its start value. All other status bits read 0. Writes to the status port have no effect, and reads of the control port return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| tick | input | 1 | Count enable; one tick per cycle in which it is high |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe; causes the read side effects |
| addr | input | 3 | Bus address: 0 to 2 data ports, 3 control, 4 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| irq | output | 1 | One-cycle interrupt pulse from channel 0 |

## Verification
The read path is combinational, so a byte is checked in the same cycle as its `rd_en`. The byte-phase or status-queue update caused by that read becomes visible from the next cycle. A control or data write takes effect at the edge that ends its cycle. A count therefore shows up in a latch read after one tick cycle plus one latch-write cycle, and the bench compares it with N-((k-1) mod N) or with the one-shot value after k ticks. The `irq` pulse is registered at the terminal tick's edge and counted at the falling edge that follows. Pulse counts are compared against (k-1)/N, or against 0 or 1 in one-shot mode, only after the later latch and read cycles have run, so no check depends on process order at an edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam logic [2:0] MODE_ONESHOT = 3'd0;
   localparam logic [2:0] MODE_SQUARE  = 3'd3;
   localparam logic [2:0] ADDR_CTRL    = 3'd3;
   localparam logic [2:0] ADDR_STAT    = 3'd4;
   localparam int         STAT_OUT_BIT = 5;
   localparam int         STAT_SQ_BIT  = 0;
   localparam logic [1:0] SEL_READBACK = 2'd3;
   localparam logic [1:0] ACC_LATCH    = 2'd0;
endpackage

// File: rtl/pit_decode.sv
module pit_decode
   import pit_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_CH-1:0] ch_wr,
   output logic [NUM_CH-1:0] ch_rd,
   output logic [NUM_CH-1:0] mode_wr,
   output logic [NUM_CH-1:0] latch_cnt,
   output logic [NUM_CH-1:0] set_status
);
   logic [1:0] sel_f;
   logic [1:0] acc_f;
   logic       ctrl_wr;
   logic       is_rb;
   logic       unused_bcd;

   assign sel_f      = wdata[7:6];
   assign acc_f      = wdata[5:4];
   assign ctrl_wr    = wr_en && (addr == ADDR_W'(ADDR_CTRL));
   assign is_rb      = (sel_f == SEL_READBACK);
   assign unused_bcd = wdata[0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      logic hit;
      assign hit           = !is_rb && (sel_f == 2'(i));
      assign ch_wr[i]      = wr_en && (addr == ADDR_W'(i));
      assign ch_rd[i]      = rd_en && (addr == ADDR_W'(i));
      assign mode_wr[i]    = ctrl_wr && hit && (acc_f != ACC_LATCH);
      assign latch_cnt[i]  = ctrl_wr && ((hit && acc_f == ACC_LATCH) ||
                                         (is_rb && !wdata[5] && wdata[1+i]));
      assign set_status[i] = ctrl_wr && is_rb && !wdata[4] && wdata[1+i];
   end

   // R2: a bus write reaches at most one data port
   p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_wr));
   // R2: a mode store never coincides with a read-back status request
   p_mode_vs_rb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(|mode_wr && |set_status));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic              mode_wr,
   input  logic [2:0]        mode_in,
   input  logic              latch_cnt,
   input  logic              set_status,
   output logic [DATA_W-1:0] rd_byte,
   output logic              fire,
   output logic              out_state,
   output logic [2:0]        mode,
   output logic              above_half
);
   logic [CNT_W-1:0]  start_q, count_q, olatch_q;
   logic [CNT_W-1:0]  new_start;
   logic [DATA_W-1:0] lo_q;
   logic wr_hi_q, rd_hi_q, stat_q, run_q, load_q, state_q, fire_q;
   logic [2:0] mode_q;

   assign new_start = {wr_data, lo_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q  <= '1;
         count_q  <= '1;
         olatch_q <= '0;
         lo_q     <= '0;
         wr_hi_q  <= 1'b0;
         rd_hi_q  <= 1'b0;
         stat_q   <= 1'b0;
         run_q    <= 1'b0;
         load_q   <= 1'b0;
         state_q  <= 1'b0;
         fire_q   <= 1'b0;
         mode_q   <= MODE_ONESHOT;
      end else begin
         fire_q <= 1'b0;
         if (mode_wr) mode_q <= mode_in;
         if (latch_cnt) olatch_q <= count_q;
         if (set_status) stat_q <= 1'b1;
         else if (data_rd && stat_q) stat_q <= 1'b0;
         if (data_rd && !stat_q) rd_hi_q <= !rd_hi_q;
         if (data_wr) begin
            if (!wr_hi_q) begin
               lo_q    <= wr_data;
               wr_hi_q <= 1'b1;
            end else begin
               start_q <= (new_start == '0) ? '1 : new_start;
               wr_hi_q <= 1'b0;
               run_q   <= 1'b1;
               load_q  <= 1'b1;
               state_q <= 1'b0;
            end
         end else if (tick && run_q) begin
            if (load_q) begin
               count_q <= start_q;
               load_q  <= 1'b0;
            end else if (count_q == CNT_W'(1)) begin
               fire_q <= 1'b1;
               if (mode_q == MODE_ONESHOT) begin
                  state_q <= 1'b1;
                  run_q   <= 1'b0;
                  count_q <= '0;
               end else begin
                  count_q <= start_q;
               end
            end else begin
               count_q <= count_q - CNT_W'(1);
            end
         end
      end
   end

   assign rd_byte    = stat_q  ? DATA_W'({2'b11, mode_q, 1'b0}) :
                       rd_hi_q ? olatch_q[CNT_W-1:DATA_W] : olatch_q[DATA_W-1:0];
   assign fire       = fire_q;
   assign out_state  = state_q;
   assign mode       = mode_q;
   assign above_half = count_q > (start_q >> 1);

   // R5: a running, loaded counter never exceeds its start value
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !load_q) |-> (count_q <= start_q));
   // R6: the stored start value is never zero
   p_start_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_q != '0);
   // R8: a status read consumes the queued status byte
   p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && stat_q && !set_status) |=> !stat_q);
   // R10: the output state rises only together with a firing
   p_state_on_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q) |-> fire_q);
   // R11: a periodic firing leaves the count at the start value
   p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_q && run_q) |-> (count_q == start_q));
endmodule

// File: rtl/pit_timer3.sv
module pit_timer3
   import pit_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int IRQ_CH = 0;
   localparam int SQ_CH  = NUM_CH - 1;

   if (NUM_CH != 3) begin : g_bad_ch
      $error("pit_timer3: NUM_CH must be 3 (2-bit select, value 3 is read-back)");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_w
      $error("pit_timer3: CNT_W must be twice DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_d
      $error("pit_timer3: DATA_W must hold a full control word");
   end
   if (ADDR_W < 3) begin : g_bad_a
      $error("pit_timer3: ADDR_W too narrow for the port map");
   end

   logic [NUM_CH-1:0] ch_wr, ch_rd, mode_wr, latch_cnt, set_status;
   logic [NUM_CH-1:0] fire, out_state, above_half;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_byte;
   logic [NUM_CH-1:0][2:0]        ch_mode;
   logic [DATA_W-1:0]             stat_byte;

   pit_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .ch_wr(ch_wr), .ch_rd(ch_rd), .mode_wr(mode_wr),
      .latch_cnt(latch_cnt), .set_status(set_status));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pit_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .wr_data(wdata),
         .data_wr(ch_wr[i]), .data_rd(ch_rd[i]), .mode_wr(mode_wr[i]),
         .mode_in(wdata[3:1]), .latch_cnt(latch_cnt[i]),
         .set_status(set_status[i]), .rd_byte(ch_byte[i]), .fire(fire[i]),
         .out_state(out_state[i]), .mode(ch_mode[i]),
         .above_half(above_half[i]));
   end

   always_comb begin
      stat_byte               = '0;
      stat_byte[STAT_OUT_BIT] = (ch_mode[SQ_CH] == MODE_ONESHOT) && out_state[SQ_CH];
      stat_byte[STAT_SQ_BIT]  = (ch_mode[SQ_CH] == MODE_SQUARE) && above_half[SQ_CH];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(i)) rdata = ch_byte[i];
      end
      if (addr == ADDR_W'(ADDR_STAT)) rdata = stat_byte;
   end

   assign irq = fire[IRQ_CH];

   // R13: only bits 5 and 0 of the status port can be set
   p_status_bits_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(ADDR_STAT)) |-> (rdata[7:6] == 2'b00 && rdata[4:1] == 4'b0000));
   // R13: the control port reads as zero
   p_ctrl_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(ADDR_CTRL)) |-> (rdata == '0));
endmodule

// File: tb/pit_timer3_test.sv
module pit_timer3_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int checks = 0;
   int failures = 0;
   int irq_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = !clk;

   pit_timer3 uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic rd16(input logic [2:0] ch, output int v);
      logic [7:0] lo, hi;
      bus_rd(ch, lo);
      bus_rd(ch, hi);
      v = {hi, lo};
   endtask

   task automatic latch16(input logic [2:0] ch, output int v);
      bus_wr(3'd3, {ch[1:0], 6'b0});
      rd16(ch, v);
   endtask

   task automatic load(input logic [2:0] ch, input logic [7:0] ctrl, input int n);
      bus_wr(3'd3, ctrl);
      bus_wr(ch, n[7:0]);
      bus_wr(ch, n[15:8]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #500000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int v, base;
      logic [7:0] b;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd16(3'd0, v);          check("R1 latch reset", v, 0);
      latch16(3'd1, v);       check("R1 start/count reset", v, 16'hFFFF);
      bus_wr(3'd3, 8'hEE);
      for (int c = 0; c < 3; c++) begin
         bus_rd(3'(c), b);    check("R1 reset mode 0", b, 8'h30);
      end
      bus_rd(3'd4, b);        check("R1 status reset", b, 0);
      bus_rd(3'd3, b);        check("R13 control read", b, 0);

      // R5 R10 R12: one-shot sweep on channel 0
      for (int n = 1; n <= 4; n++) begin
         load(3'd0, 8'h30, n);
         base = irq_cnt;
         for (int k = 1; k <= n + 3; k++) begin
            ticks(1);
            latch16(3'd0, v);
            check("R5/R10 oneshot count", v, (k <= n) ? n - (k - 1) : 0);
            check("R10/R12 oneshot irq", irq_cnt - base, (k > n) ? 1 : 0);
         end
      end

      // R11 R12: periodic sweep on channel 0
      for (int n = 1; n <= 5; n++) begin
         load(3'd0, 8'h34, n);
         base = irq_cnt;
         for (int k = 1; k <= 2 * n + 2; k++) begin
            ticks(1);
            latch16(3'd0, v);
            check("R11 periodic count", v, n - ((k - 1) % n));
            check("R11/R12 periodic irq", irq_cnt - base, (k - 1) / n);
         end
      end

      // R6: zero start becomes 0xFFFF
      load(3'd0, 8'h30, 0);
      ticks(1);
      latch16(3'd0, v);       check("R6 zero start", v, 16'hFFFF);
      base = irq_cnt;

      // R12 R2: channel 1 periodic never drives irq; channels independent
      load(3'd1, 8'h76, 3);
      ticks(12);
      check("R12 ch1 no irq", irq_cnt - base, 0);
      latch16(3'd0, v);       check("R2 ch0 independent", v, 16'hFFF3);
      latch16(3'd1, v);       check("R2 ch1 count", v, 1);

      // R3 R8: latch keeps mode; status read leaves byte phase
      bus_wr(3'd3, 8'h40);
      bus_wr(3'd3, 8'hE4);
      bus_rd(3'd1, b);        check("R3/R8 status after latch", b, 8'h36);
      rd16(3'd1, v);          check("R8 phase kept", v, 1);

      // R9: read-back count on channels 0 and 1
      ticks(2);
      bus_wr(3'd3, 8'hD6);
      rd16(3'd0, v);          check("R9 rb count ch0", v, 16'hFFF1);
      rd16(3'd1, v);          check("R9 rb count ch1", v, 2);
      bus_wr(3'd3, 8'hC2);
      bus_rd(3'd0, b);        check("R8 combined status", b, 8'h30);
      rd16(3'd0, v);          check("R9 combined count", v, 16'hFFF1);

      // R4: mode stored with other access fields
      bus_wr(3'd3, 8'h92);
      bus_wr(3'd3, 8'hE8);
      bus_rd(3'd2, b);        check("R4 access 01 mode", b, 8'h32);
      bus_wr(3'd3, 8'hA4);
      bus_wr(3'd3, 8'hE8);
      bus_rd(3'd2, b);        check("R4 access 10 mode", b, 8'h34);

      // R13: status port, channel 2 one-shot
      load(3'd2, 8'hB0, 2);
      bus_rd(3'd4, b);        check("R13 status before fire", b, 0);
      ticks(3);
      bus_rd(3'd4, b);        check("R13 status bit5", b, 8'h20);
      bus_wr(3'd4, 8'hFF);
      bus_rd(3'd4, b);        check("R13 status write ignored", b, 8'h20);
      latch16(3'd2, v);       check("R13 ch2 unaffected by status write", v, 0);

      // R13: status port, channel 2 square wave
      load(3'd2, 8'hB6, 6);
      for (int k = 1; k <= 8; k++) begin
         ticks(1);
         v = 6 - ((k - 1) % 6);
         bus_rd(3'd4, b);     check("R13 square bit0", b, (v > 3) ? 1 : 0);
      end

      // R7: byte alternation
      load(3'd1, 8'h74, 16'h1234);
      ticks(1);
      bus_wr(3'd3, 8'h40);
      for (int r = 0; r < 4; r++) begin
         bus_rd(3'd1, b);     check("R7 alternation", b, (r % 2 == 0) ? 8'h34 : 8'h12);
      end

      finish_run();
   end
endmodule